// File: doc/BRIEF.md
# Unified Forward/Inverse Modular Butterfly

This block is the radix-2 arithmetic core of a pipelined number theoretic transform stage for the prime modulus 3329. It takes two 12-bit coefficients `a` and `b`, a 12-bit twiddle `w` and a mode bit. It returns two 12-bit coefficients two clock cycles later. In forward mode it performs the decimation-in-time (Cooley-Tukey) butterfly. In inverse mode it performs the decimation-in-frequency (Gentleman-Sande) butterfly, and it halves both results modulo 3329. Repeating that halving at every stage of an inverse transform supplies the final 1/n scaling.

One modular adder, one modular subtractor and one modular multiplier are shared by both modes. Multiplexers steer them. In forward mode the multiplier sits in front of the adder and subtractor. In inverse mode the adder and subtractor sit in front of the multiplier. A bypass delay line carries whichever value skips the multiplier, so both outputs leave on the same cycle. The multiplier is split into a product register and a reduction register. A valid flag travels with the data.

The surrounding stage controller accepts one operation per cycle. It changes the mode bit only when no operation is in flight. Operands must already be reduced, that is below 3329.

Top module: `bfly_unit`

## Requirements
- R1: With `inv_mode` = 0 (forward), `x_out` = (a + w·b) mod 3329 and `y_out` = (a − w·b) mod 3329.
- R2: With `inv_mode` = 1 (inverse), `x_out` = ((a + b)·h) mod 3329 and `y_out` = ((a − b)·w·h) mod 3329, where h = 1665 is the inverse of 2 modulo 3329.
- R3: `out_valid` rises exactly two clock cycles after an accepted `in_valid`, in both modes. The two results that belong to that operation are present on `x_out`/`y_out` in that same cycle.
- R4: For operands below 3329, every valid `x_out` and `y_out` lies in 0..3328.
- R5: While `rst_n` is low, and until the first valid operation has passed through, `out_valid` is 0.
- R6: A new operation may be accepted every cycle. A cycle with `in_valid` = 0 gives a cycle with `out_valid` = 0 two cycles later.
- R7: Inverse-mode halving of an odd intermediate value yields (v + 3329)/2. For example, a = 1, b = 0, w = 1 gives 1665 on both outputs. Operand extremes (all 3328, or zero twiddle) wrap correctly in both modes.
- R8: A change of `inv_mode` made while the pipeline is empty takes effect on the very next accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| inv_mode | input | 1 | 0 = forward butterfly, 1 = inverse butterfly with halving |
| a_in | input | 12 | First coefficient, below 3329 |
| b_in | input | 12 | Second coefficient, below 3329 |
| w_in | input | 12 | Twiddle factor, below 3329 |
| out_valid | output | 1 | Results on `x_out`/`y_out` are valid |
| x_out | output | 12 | Upper butterfly result |
| y_out | output | 12 | Lower butterfly result |

## Verification
Every result is due exactly two rising edges after the edge that samples the operation. The bench therefore drives inputs on the falling edge and queues one expected record per cycle. It pops the record two falling edges later and compares `out_valid`, `x_out` and `y_out` in that cycle. Idle cycles are queued as well, so a result that comes a cycle early or late shows up as a valid-flag mismatch. Before each mode change, two idle cycles drain the pipeline. The first operation after the change is tagged separately.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Coefficient width and prime modulus of the transform
    localparam int unsigned COEF_W  = 12;
    localparam int unsigned MODULUS = 3329;

    // Mode bit encoding
    typedef enum logic {
        MODE_CT = 1'b0,   // forward: multiply first, then add/subtract
        MODE_GS = 1'b1    // inverse: add/subtract first, then multiply, then halve
    } bfly_mode_e;

endpackage

// File: rtl/bfly_mod_add.sv
module bfly_mod_add #(
    parameter int unsigned W = 12,
    parameter int unsigned Q = 3329
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W:0]   raw;
    logic [W+1:0] trial;

    always_comb begin
        raw   = {1'b0, a} + {1'b0, b};
        trial = {1'b0, raw} - (W+2)'(Q);
        // a borrow out of the trial subtraction means raw was already below Q
        s     = trial[W+1] ? W'(raw) : W'(trial);
    end
endmodule

// File: rtl/bfly_mod_sub.sv
module bfly_mod_sub #(
    parameter int unsigned W = 12,
    parameter int unsigned Q = 3329
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] d
);
    logic [W:0] raw;
    logic [W:0] lifted;

    always_comb begin
        raw    = {1'b0, a} - {1'b0, b};
        lifted = raw + (W+1)'(Q);
        // the sign bit of the raw difference picks the corrected value
        d      = raw[W] ? W'(lifted) : W'(raw);
    end
endmodule

// File: rtl/bfly_mod_red.sv
module bfly_mod_red #(
    parameter int unsigned W = 12,
    parameter int unsigned Q = 3329
) (
    input  logic [2*W-1:0] p,
    output logic [W-1:0]   r
);
    localparam int unsigned     K = 2 * W;
    localparam longint unsigned M = (64'd1 << K) / Q;

    logic [2*K-1:0] pm;
    logic [K-1:0]   quot;
    logic [K-1:0]   r0;
    logic [K-1:0]   r1;
    logic [K-1:0]   r2;

    always_comb begin
        // quotient estimate, never above the true quotient and at most two below it
        pm   = (2*K)'(p) * (2*K)'(M);
        quot = K'(pm >> K);
        r0   = p - K'(quot * K'(Q));
        r1   = (r0 >= K'(Q)) ? r0 - K'(Q) : r0;
        r2   = (r1 >= K'(Q)) ? r1 - K'(Q) : r1;
        r    = W'(r2);
    end
endmodule

// File: rtl/bfly_mod_half.sv
module bfly_mod_half #(
    parameter int unsigned W = 12,
    parameter int unsigned Q = 3329
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] h
);
    logic [W:0] even_val;

    always_comb begin
        // an odd residue is made even by adding the odd modulus, then shifted
        even_val = x[0] ? ({1'b0, x} + (W+1)'(Q)) : {1'b0, x};
        h        = W'(even_val >> 1);
    end
endmodule

// File: rtl/bfly_unit.sv
module bfly_unit
    import bfly_pkg::*;
#(
    parameter int unsigned W = COEF_W,
    parameter int unsigned Q = MODULUS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         inv_mode,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] w_in,
    output logic         out_valid,
    output logic [W-1:0] x_out,
    output logic [W-1:0] y_out
);
    localparam int unsigned PW     = 2 * W;
    localparam int unsigned N_HALF = 2;

    typedef struct packed {
        logic          v1;        // valid, first pipeline register
        logic          v2;        // valid, second pipeline register
        logic [W-1:0]  byp1;      // bypass line, first register
        logic [W-1:0]  byp2;      // bypass line, second register
        logic [PW-1:0] prod_raw;  // full-width product
        logic [W-1:0]  prod_red;  // reduced product
    } pipe_t;

    pipe_t st_d, st_q;

    logic         gs_sel;
    logic [W-1:0] add_op_a, add_op_b, add_res;
    logic [W-1:0] sub_op_a, sub_op_b, sub_res;
    logic [W-1:0] mul_op;
    logic [W-1:0] red_res;
    logic [W-1:0] half_in  [N_HALF];
    logic [W-1:0] half_out [N_HALF];

    assign gs_sel = (bfly_mode_e'(inv_mode) == MODE_GS);

    // Shared arithmetic: the one adder and the one subtractor
    bfly_mod_add #(.W(W), .Q(Q)) u_add (
        .a (add_op_a),
        .b (add_op_b),
        .s (add_res)
    );

    bfly_mod_sub #(.W(W), .Q(Q)) u_sub (
        .a (sub_op_a),
        .b (sub_op_b),
        .d (sub_res)
    );

    // Second half of the multiplier: reduction of the registered product
    bfly_mod_red #(.W(W), .Q(Q)) u_red (
        .p (st_q.prod_raw),
        .r (red_res)
    );

    // Inverse-mode halving, one per output
    assign half_in[0] = st_q.byp2;
    assign half_in[1] = st_q.prod_red;

    for (genvar gi = 0; gi < N_HALF; gi++) begin : g_half
        bfly_mod_half #(.W(W), .Q(Q)) u_half (
            .x (half_in[gi]),
            .h (half_out[gi])
        );
    end

    // Next-state and steering
    always_comb begin
        // Operand steering: forward uses the pipeline tail, inverse uses the inputs
        add_op_a = gs_sel ? a_in : st_q.byp2;
        add_op_b = gs_sel ? b_in : st_q.prod_red;
        sub_op_a = add_op_a;
        sub_op_b = add_op_b;

        // Forward multiplies b; inverse multiplies the difference
        mul_op = gs_sel ? sub_res : b_in;

        st_d          = st_q;
        st_d.v1       = in_valid;
        st_d.v2       = st_q.v1;
        st_d.byp1     = gs_sel ? add_res : a_in;
        st_d.byp2     = st_q.byp1;
        st_d.prod_raw = PW'(mul_op) * PW'(w_in);
        st_d.prod_red = red_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Output selection
    always_comb begin
        out_valid = st_q.v2;
        x_out     = gs_sel ? half_out[0] : add_res;
        y_out     = gs_sel ? half_out[1] : sub_res;
    end

endmodule

// File: rtl/bfly_unit_chk.sv
module bfly_unit_chk #(
    parameter int unsigned W = 12,
    parameter int unsigned Q = 3329
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         inv_mode,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] w_in,
    input logic         out_valid,
    input logic [W-1:0] x_out,
    input logic [W-1:0] y_out
);
    localparam longint HALF_INV = (longint'(Q) + 1) / 2;

    function automatic longint md(input longint v);
        return ((v % longint'(Q)) + longint'(Q)) % longint'(Q);
    endfunction

    function automatic longint exp_fx(input logic [W-1:0] a, b, w);
        return md(longint'(a) + md(longint'(w) * longint'(b)));
    endfunction

    function automatic longint exp_fy(input logic [W-1:0] a, b, w);
        return md(longint'(a) - md(longint'(w) * longint'(b)));
    endfunction

    function automatic longint exp_ix(input logic [W-1:0] a, b);
        return md(md(longint'(a) + longint'(b)) * HALF_INV);
    endfunction

    function automatic longint exp_iy(input logic [W-1:0] a, b, w);
        return md(md(md(longint'(a) - longint'(b)) * longint'(w)) * HALF_INV);
    endfunction

    // R3: an accepted operation leaves exactly two cycles later
    a_r3_valid_due: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R6: an idle input cycle gives an idle output cycle
    a_r6_idle_due: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R4: valid results stay reduced
    a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (x_out < W'(Q)) && (y_out < W'(Q)));

    // R1: forward results against the operands sampled two edges earlier
    a_r1_fwd_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !inv_mode) |->
            (longint'(x_out) == exp_fx($past(a_in, 2), $past(b_in, 2), $past(w_in, 2))) &&
            (longint'(y_out) == exp_fy($past(a_in, 2), $past(b_in, 2), $past(w_in, 2))));

    // R2: inverse results with halving
    a_r2_inv_result: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && inv_mode) |->
            (longint'(x_out) == exp_ix($past(a_in, 2), $past(b_in, 2))) &&
            (longint'(y_out) == exp_iy($past(a_in, 2), $past(b_in, 2), $past(w_in, 2))));

    // R5: reset clears the valid flag
    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind bfly_unit bfly_unit_chk #(.W(W), .Q(Q)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .inv_mode  (inv_mode),
    .a_in      (a_in),
    .b_in      (b_in),
    .w_in      (w_in),
    .out_valid (out_valid),
    .x_out     (x_out),
    .y_out     (y_out)
);

// File: tb/bfly_unit_tb.sv
`timescale 1ns/1ps
module bfly_unit_tb;
    localparam int QM   = 3329;
    localparam int HINV = 1665;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        inv_mode = 1'b0;
    logic [11:0] a_in = '0;
    logic [11:0] b_in = '0;
    logic [11:0] w_in = '0;
    logic        out_valid;
    logic [11:0] x_out;
    logic [11:0] y_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit    v;
        int    x;
        int    y;
        string tag;
    } exp_t;

    exp_t pipe[$];

    always #2.5 clk = ~clk;

    bfly_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .inv_mode  (inv_mode),
        .a_in      (a_in),
        .b_in      (b_in),
        .w_in      (w_in),
        .out_valid (out_valid),
        .x_out     (x_out),
        .y_out     (y_out)
    );

    function automatic int md(input longint v);
        return int'(((v % QM) + QM) % QM);
    endfunction

    task automatic check_int(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic check_head();
        exp_t e;
        e = pipe.pop_front();
        check_int(e.tag, "out_valid", int'(out_valid), int'(e.v));
        if (e.v) begin
            check_int(e.tag, "x_out", int'(x_out), e.x);
            check_int(e.tag, "y_out", int'(y_out), e.y);
            check_int("R4", "x_out<q", int'(x_out < 12'(QM)), 1);
            check_int("R4", "y_out<q", int'(y_out < 12'(QM)), 1);
        end
    endtask

    // One cycle: compare the record due now, then drive and queue a new one
    task automatic step(input bit v, input bit m, input int a, input int b, input int w, input string tag);
        exp_t e;
        @(negedge clk);
        check_head();
        in_valid = v;
        inv_mode = m;
        a_in     = 12'(a);
        b_in     = 12'(b);
        w_in     = 12'(w);
        e.v   = v;
        e.tag = tag;
        if (!m) begin
            e.x = md(longint'(a) + longint'(w) * b);
            e.y = md(longint'(a) - longint'(w) * b);
        end else begin
            e.x = md(longint'(md(longint'(a) + b)) * HINV);
            e.y = md(longint'(md(longint'(md(longint'(a) - b)) * w)) * HINV);
        end
        pipe.push_back(e);
    endtask

    task automatic idle(input bit m, input int n);
        for (int i = 0; i < n; i++) step(1'b0, m, 0, 0, 0, "R6");
    endtask

    initial begin
        exp_t blank;
        // R5: valid stays low during reset
        repeat (3) begin
            @(negedge clk);
            check_int("R5", "out_valid in reset", int'(out_valid), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        blank.v = 1'b0; blank.x = 0; blank.y = 0; blank.tag = "R5";
        pipe.push_back(blank);
        pipe.push_back(blank);

        // R1 forward corners
        step(1'b1, 1'b0, 0, 0, 0, "R1");
        step(1'b1, 1'b0, 3328, 3328, 3328, "R7");
        step(1'b1, 1'b0, 1, 3328, 1, "R1");
        step(1'b1, 1'b0, 3328, 0, 17, "R1");
        step(1'b1, 1'b0, 5, 7, 0, "R7");
        step(1'b1, 1'b0, 0, 1, 3328, "R1");
        // R6: gaps between operations
        step(1'b0, 1'b0, 9, 9, 9, "R6");
        step(1'b1, 1'b0, 100, 200, 300, "R6");
        step(1'b0, 1'b0, 1, 2, 3, "R6");
        // R1 back-to-back random stream with random gaps
        for (int i = 0; i < 300; i++) begin
            bit vv = ($urandom % 5) != 0;
            step(vv, 1'b0, int'($urandom % QM), int'($urandom % QM), int'($urandom % QM), "R1");
        end

        // R8: drain, then switch to inverse
        idle(1'b0, 2);
        step(1'b1, 1'b1, 10, 3, 7, "R8");
        // R7 odd halving and extremes in inverse mode
        step(1'b1, 1'b1, 1, 0, 1, "R7");
        step(1'b1, 1'b1, 0, 1, 1, "R7");
        step(1'b1, 1'b1, 3328, 3328, 3328, "R7");
        step(1'b1, 1'b1, 3328, 0, 0, "R7");
        step(1'b1, 1'b1, 0, 3328, 3328, "R2");
        for (int i = 0; i < 300; i++) begin
            bit vv = ($urandom % 4) != 0;
            step(vv, 1'b1, int'($urandom % QM), int'($urandom % QM), int'($urandom % QM), "R2");
        end

        // R8: drain, then back to forward
        idle(1'b1, 2);
        step(1'b1, 1'b0, 2, 3, 4, "R8");
        for (int i = 0; i < 50; i++) begin
            step(1'b1, 1'b0, int'($urandom % QM), int'($urandom % QM), int'($urandom % QM), "R3");
        end
        idle(1'b0, 3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule